// File: doc/BRIEF.md
# Prescaled Single-Output PWM Generator

This block produces one pulse-width-modulated output from three software-visible words: control, sample and period. A tick from one of three clock-enable sources, picked by a field in the control word, goes through a 12-bit divider. Each divider tick moves a counter that climbs from zero to one past the programmed period and then returns to zero. The output is high while the counter sits below the sample value.

The sample and period words are copied into working copies only when the counter wraps, or at any time while the generator is off. A new configuration therefore never produces a clipped or stretched cycle. Four low-power inputs (stop, doze, wait, debug) freeze the counter unless the matching run-enable bit in the control word is set. A register port with single-cycle writes and combinational reads holds the configuration.

Top module: `pwm_gen`

## Requirements
- R1: The control word is at offset 0x00, the sample word at 0x0C and the period word at 0x10. Control implements bit 0 (enable), bits [15:4] (divide ratio minus one), bits [17:16] (source) and bits 22..25 (run enables), so a write of all ones reads back 0x03C3FFF1. Sample and period keep their low 16 bits. Any other offset reads zero, and a write to it changes nothing.
- R2: After reset every register reads zero and the output is low.
- R3: With divider field D and period word P, the output repeats every (P+2)*(D+1) selected source ticks.
- R4: Within each cycle the output is high while the counter is below the sample word S, and low from then on. S=0 gives a constant low output. S>P+1 gives a constant high output.
- R5: Source codes 1, 2 and 3 select src_tick_i bits 0, 1 and 2. Code 0 selects no source, and the counter and output then hold.
- R6: lp_i bits 0..3 (debug, wait, doze, stop) each freeze the counter and output while high, unless the control bit at position 22, 23, 24 or 25 respectively is set. When that bit is set, the generator runs normally.
- R7: A write to sample or period during a cycle leaves that cycle unchanged. The new values apply from the next counter wrap onward.
- R8: While enable is low, the divider and counter are held at zero and the output is low. On enabling, a cycle starts at counter zero, so the output is high at once when S>0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write qualifier for req_i |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| src_tick_i | input | 3 | Clock-enable ticks of the three selectable sources |
| lp_i | input | 4 | Low-power mode flags: debug, wait, doze, stop |
| pwm_o | output | 1 | PWM output |

## Verification
A write is captured on the rising edge that follows the strobe. The output depends only on registers, so it reflects that write one edge later, and the bench samples it on the falling edge just after. Reads are combinational and are sampled 1 ns after the address is driven. Periodic results are taken as high-cycle counts over a whole number of cycles that starts at enable, together with the spacing between rising edges. Because they do not depend on phase, no exact edge index is assumed except in the wrap-update test. That test first syncs to a rising edge, which is counter zero, and then compares a 15-sample pattern that is fixed cycle by cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [4:0]  OFS_CTRL   = 5'h00;
  localparam logic [4:0]  OFS_SAMPLE = 5'h0C;
  localparam logic [4:0]  OFS_PERIOD = 5'h10;
  localparam int          EN_BIT     = 0;
  localparam int          PRE_LSB    = 4;
  localparam int          SRC_LSB    = 16;
  localparam int          RUN_LSB    = 22;
  localparam logic [31:0] CTRL_MASK  = 32'h03C3_FFF1;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output logic [PRE_W-1:0]  presc_o,
  output logic [1:0]        src_o,
  output logic [3:0]        run_en_o,
  output logic [CNT_W-1:0]  sample_o,
  output logic [CNT_W-1:0]  period_o
);
  logic [DATA_W-1:0] ctrl_q, sample_q, period_q;
  logic              wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      sample_q <= '0;
      period_q <= '0;
    end else if (wr) begin
      case (addr_i)
        ADDR_W'(OFS_CTRL):   ctrl_q   <= wdata_i & DATA_W'(CTRL_MASK);
        ADDR_W'(OFS_SAMPLE): sample_q <= DATA_W'(wdata_i[CNT_W-1:0]);
        ADDR_W'(OFS_PERIOD): period_q <= DATA_W'(wdata_i[CNT_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(OFS_CTRL):   rdata_o = ctrl_q;
      ADDR_W'(OFS_SAMPLE): rdata_o = sample_q;
      ADDR_W'(OFS_PERIOD): rdata_o = period_q;
      default:             rdata_o = '0;
    endcase
  end

  assign en_o     = ctrl_q[EN_BIT];
  assign presc_o  = ctrl_q[PRE_LSB +: PRE_W];
  assign src_o    = ctrl_q[SRC_LSB +: 2];
  assign run_en_o = ctrl_q[RUN_LSB +: 4];
  assign sample_o = sample_q[CNT_W-1:0];
  assign period_o = period_q[CNT_W-1:0];

  AST_SAMPLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFS_SAMPLE)) |=> sample_o == $past(wdata_i[CNT_W-1:0])); // R1
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [PRE_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;

  // >= keeps a shrinking ratio from running the divider past its limit
  assign tick_o = adv_i && (div_q >= ratio_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clr_i)   div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else if (adv_i)   div_q <= div_q + PRE_W'(1);
  end

  AST_PRE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> div_q == '0); // R3
  AST_PRE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(div_q)); // R5
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] sample_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             pwm_o
);
  localparam int CW = CNT_W + 1;

  logic [CW-1:0]    cnt_q, lim;
  logic [CNT_W-1:0] sample_act_q, period_act_q;

  assign lim = {1'b0, period_act_q} + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      sample_act_q <= '0;
      period_act_q <= '0;
    end else if (!en_i) begin
      cnt_q        <= '0;
      sample_act_q <= sample_i;
      period_act_q <= period_i;
    end else if (step_i) begin
      if (cnt_q >= lim) begin
        cnt_q        <= '0;
        sample_act_q <= sample_i;
        period_act_q <= period_i;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign pwm_o = en_i && ({1'b0, sample_act_q} > cnt_q);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> cnt_q <= {1'b0, period_act_q} + CW'(1)); // R3
  AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0); // R8
  AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !step_i) |=> $stable(cnt_q)); // R5
  AST_SHADOW_MID_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && cnt_q != '0) |-> ($stable(period_act_q) && $stable(sample_act_q))); // R7
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [2:0]        src_tick_i,
  input  logic [3:0]        lp_i,
  output logic              pwm_o
);
  logic             en;
  logic [PRE_W-1:0] presc;
  logic [1:0]       src;
  logic [3:0]       run_en;
  logic [CNT_W-1:0] sample, period;
  logic             src_tick, frozen, adv, step;

  pwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .en_o(en), .presc_o(presc), .src_o(src), .run_en_o(run_en),
    .sample_o(sample), .period_o(period)
  );

  always_comb begin
    case (src)
      2'd1:    src_tick = src_tick_i[0];
      2'd2:    src_tick = src_tick_i[1];
      2'd3:    src_tick = src_tick_i[2];
      default: src_tick = 1'b0;
    endcase
  end

  // a low-power flag stalls the count unless its run-enable is set
  assign frozen = |(lp_i & ~run_en);
  assign adv    = en & src_tick & ~frozen;

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(~en), .adv_i(adv), .ratio_i(presc), .tick_o(step)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .en_i(en), .step_i(step),
    .sample_i(sample), .period_i(period), .pwm_o
  );

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !pwm_o); // R8
  AST_FROZEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && $past(en) && $past(frozen)) |-> $stable(pwm_o)); // R6
endmodule

// File: tb/pwm_gen_bench.sv
module pwm_gen_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  tick = 3'b111;
  logic [3:0]  lp = '0;
  logic        pwm;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  localparam logic [4:0] A_CTRL = 5'h00, A_SMP = 5'h0C, A_PER = 5'h10;

  always #4 clk = ~clk;

  pwm_gen u_pwm_gen (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_tick_i(tick), .lp_i(lp), .pwm_o(pwm)
  );

  task automatic check(input string req_s, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_s, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic setup(input int pre, input int src, input int run, input int per, input int smp);
    wr(A_CTRL, 0);
    wr(A_SMP, smp);
    wr(A_PER, per);
    wr(A_CTRL, 32'(1 | (pre << 4) | (src << 16) | (run << 22)));
  endtask

  task automatic measure(input int n, input bit tog, output int highs, output int gap, output int chg);
    logic prev;
    int first;
    prev = pwm; highs = 0; gap = 0; chg = 0; first = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tog) tick[1] = ~tick[1];
      if (pwm) highs++;
      if (pwm !== prev) chg++;
      if (pwm && !prev) begin
        if (first < 0) first = i;
        else if (gap == 0) gap = i - first;
      end
      prev = pwm;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_CTRL, d); check("R2 ctrl", d, 0);
    rd(A_SMP, d);  check("R2 sample", d, 0);
    rd(A_PER, d);  check("R2 period", d, 0);
    check("R2 pwm", pwm, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); check("R1 ctrl mask", d, 32'h03C3_FFF1);
    wr(A_CTRL, 0);
    wr(A_SMP, 32'hABCD_1234);
    rd(A_SMP, d); check("R1 sample width", d, 32'h1234);
    wr(A_PER, 32'h5555_8765);
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, d); check("R1 unmapped read", d, 0);
    rd(A_PER, d); check("R1 period kept", d, 32'h8765);
    rd(A_SMP, d); check("R1 sample kept", d, 32'h1234);
    rd(A_CTRL, d); check("R1 ctrl kept", d, 0);
  endtask

  task automatic t_basic;
    int h, g, c;
    tick = 3'b111;
    setup(0, 1, 0, 3, 2);
    measure(50, 0, h, g, c);
    check("R3 highs P3 S2", h, 20);
    check("R3 gap P3", g, 5);
    check("R4 edges", c, 20);
  endtask

  task automatic t_prescale;
    int h, g, c;
    setup(2, 1, 0, 1, 1);
    measure(90, 0, h, g, c);
    check("R3 highs div3", h, 30);
    check("R3 gap div3", g, 9);
  endtask

  task automatic t_extremes;
    int h, g, c;
    setup(0, 1, 0, 3, 0);
    measure(40, 0, h, g, c);
    check("R4 sample0 low", h, 0);
    setup(0, 1, 0, 2, 10);
    measure(40, 0, h, g, c);
    check("R4 sample above high", h, 40);
  endtask

  task automatic t_source;
    int h, g, c;
    setup(0, 0, 0, 3, 2);
    measure(30, 0, h, g, c);
    check("R5 src0 held high", h, 30);
    check("R5 src0 no edges", c, 0);
    tick = 3'b101;
    setup(0, 2, 0, 3, 2);
    measure(100, 1, h, g, c);
    check("R5 src2 highs", h, 40);
    check("R5 src2 gap", g, 10);
    tick = 3'b011;
    setup(0, 3, 0, 3, 2);
    measure(30, 0, h, g, c);
    check("R5 src3 idle held", c, 0);
    tick = 3'b111;
    setup(0, 3, 0, 3, 2);
    measure(50, 0, h, g, c);
    check("R5 src3 running", h, 20);
  endtask

  task automatic t_lowpower;
    int h, g, c;
    for (int k = 0; k < 4; k++) begin
      lp = '0;
      setup(0, 1, 0, 3, 2);
      repeat (2) @(negedge clk);
      lp[k] = 1'b1;
      measure(30, 0, h, g, c);
      check($sformatf("R6 mode%0d frozen", k), c, 0);
      lp = '0;
      setup(0, 1, 1 << k, 3, 2);
      lp[k] = 1'b1;
      measure(50, 0, h, g, c);
      check($sformatf("R6 mode%0d runs", k), h, 20);
      lp = '0;
    end
  endtask

  task automatic t_shadow;
    logic [14:0] seq;
    logic prev;
    int guard;
    setup(0, 1, 0, 3, 2);
    prev = 1'b1; guard = 0;
    do begin
      @(negedge clk);
      guard++;
      if (pwm && !prev) break;
      prev = pwm;
    end while (guard < 20);
    seq = '0;
    seq[0] = pwm;
    for (int i = 1; i < 15; i++) begin
      if (i == 1) begin req = 1; we = 1; addr = A_SMP; wdata = 4; end
      if (i == 2) begin addr = A_PER; wdata = 7; end
      if (i == 3) begin req = 0; we = 0; end
      @(negedge clk);
      seq[i] = pwm;
    end
    req = 0; we = 0;
    check("R7 wrap update pattern", seq, 15'h41E3);
  endtask

  task automatic t_disable;
    int h, g, c;
    setup(0, 1, 0, 3, 2);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 0);
    check("R8 off low", pwm, 0);
    measure(20, 0, h, g, c);
    check("R8 stays low", h, 0);
    wr(A_CTRL, 32'h0001_0001);
    check("R8 restart high", pwm, 1);
    measure(49, 0, h, g, c);
    check("R8 restart cycle", h, 19);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_basic;
    t_prescale;
    t_extremes;
    t_source;
    t_lowpower;
    t_shadow;
    t_disable;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule